// File: doc/BRIEF.md
# Alarm and Interrupt Controller

This block merges three event sources into a single interrupt request for a real-time clock. One source is a time-of-day alarm that compares stored alarm seconds, minutes and hours against the live time. Another is a periodic tick chosen from fifteen incoming rate strobes. The last is a power-fail pulse from an external line monitor. The interrupt line models an open-drain pull-down. It is active while any latched cause is pending and released otherwise.

Software writes the alarm registers and a control byte through a simple register port. The control byte sets the periodic rate and enables the alarm and power-fail sources. Software then reads a status byte that names the cause. That read also clears the latched causes. The live time arrives in BCD from the timekeeping counters. The rate strobes and power-fail pulse come from logic outside this block.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, `irq_low` is 0, the status byte reads 0x00 and the control byte reads 0x00.
- R2: When control bit 4 is set, status bit 0 is set on the cycle the live time first equals the alarm registers. The comparison uses seconds bits 6:0, minutes bits 6:0 and hours bits 5:0. Higher bits are ignored.
- R3: Hours bit 5 carries PM in 12-hour format and is part of the hour comparison, so an AM/PM difference alone gives no alarm.
- R4: The alarm flag is raised once per entry into a match. It is not raised again while the time stays equal, even after the status byte has been read.
- R5: Control bits 3:0 hold k. When k is 1 to 15, a pulse on `tick_vec[k-1]` sets status bit 1. k = 0 disables the periodic source, and pulses on unselected strobes are ignored.
- R6: A `pwr_fail` pulse sets status bit 2 only when control bit 5 is set. Otherwise it is ignored.
- R7: A read asserts `rd_en` with an address. The data appears on `rdata` on the next cycle. The status byte is at 0x30, with bit 0 alarm, bit 1 periodic and bit 2 power-fail. The control byte is at 0x32, and writes to 0x32 set it.
- R8: Reading the status byte clears every flag. A source event in the same cycle as that read remains set afterwards.
- R9: `irq_low` is 1 exactly while any flag is set. Flags stay set until the status byte is read.
- R10: Writes to 0x28, 0x29 and 0x2A load the alarm seconds, minutes and hours. Reads of those addresses return 0x00, as do reads of unmapped addresses.
- R11: A mismatch in any single field (seconds, minutes or hours) gives no alarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after `rd_en` |
| now_sec | input | 8 | Live seconds, BCD |
| now_min | input | 8 | Live minutes, BCD |
| now_hr | input | 8 | Live hours, BCD, bit 5 PM in 12-hour format |
| tick_vec | input | 15 | Periodic rate strobes, one pulse per period |
| pwr_fail | input | 1 | Power-fail pulse |
| irq_low | output | 1 | 1 = pull the shared interrupt line low |

## Verification
The bench walks a table of alarm settings against live times, including single-field mismatches, an AM/PM mismatch and ignored upper bits. For each row it checks both `irq_low` and the status byte.

A faulty match latch would show up one cycle after the time changes. Either the flag would be missing, or a second flag would appear after the status read while the time still matches.

A wrong rate decode or enable gate would show up one cycle after the strobe. Either the status bit would be wrong or `irq_low` would go high when it should not.

A clear that loses a coincident event would show up on the read right after it.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

    localparam int DATA_W    = 8;
    localparam int RATE_W    = 4;
    localparam int NUM_RATES = 15;

    localparam logic [7:0] ADDR_ALM_SEC = 8'h28;
    localparam logic [7:0] ADDR_ALM_MIN = 8'h29;
    localparam logic [7:0] ADDR_ALM_HR  = 8'h2A;
    localparam logic [7:0] ADDR_STATUS  = 8'h30;
    localparam logic [7:0] ADDR_CTRL    = 8'h32;

    typedef struct packed {
        logic              pwr_en;
        logic              alarm_en;
        logic [RATE_W-1:0] rate;
    } ctrl_t;

    typedef struct packed {
        logic pwr;
        logic tick;
        logic alarm;
    } flags_t;

    typedef struct packed {
        logic [6:0] sec;
        logic [6:0] min;
        logic [5:0] hr;
    } tod_t;

    function automatic tod_t to_tod(input logic [7:0] s, input logic [7:0] m,
                                    input logic [7:0] h);
        tod_t t;
        t.sec = s[6:0];
        t.min = m[6:0];
        t.hr  = h[5:0];
        return t;
    endfunction

    function automatic logic [7:0] status_byte(input flags_t f);
        return {5'b0, f};
    endfunction

    function automatic logic [7:0] ctrl_byte(input ctrl_t c);
        return {2'b0, c};
    endfunction

endpackage

// File: rtl/irq_alarm_unit.sv
module irq_alarm_unit
    import irq_ctrl_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [7:0]    addr,
    input  logic [DW-1:0] wdata,
    input  tod_t          now,
    output logic          alarm_rise
);
    tod_t alm_q;
    logic match;
    logic match_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            alm_q <= '0;
        end else if (wr_en) begin
            case (addr)
                ADDR_ALM_SEC: alm_q.sec <= wdata[6:0];
                ADDR_ALM_MIN: alm_q.min <= wdata[6:0];
                ADDR_ALM_HR:  alm_q.hr  <= wdata[5:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        match = (now.sec == alm_q.sec) && (now.min == alm_q.min) &&
                (now.hr == alm_q.hr);
    end

    // Starts high so a default match out of reset gives no edge.
    always_ff @(posedge clk) begin
        if (rst) match_q <= 1'b1;
        else     match_q <= match;
    end

    assign alarm_rise = match && !match_q;

    // R4
    alarm_once_chk: assert property (@(posedge clk) disable iff (rst)
        alarm_rise |=> !alarm_rise);

endmodule

// File: rtl/irq_tick_sel.sv
module irq_tick_sel #(
    parameter int NUM_RATES = 15,
    parameter int SEL_W     = $clog2(NUM_RATES + 1)
) (
    input  logic [SEL_W-1:0]     sel,
    input  logic [NUM_RATES-1:0] ticks,
    output logic                 hit
);
    logic [NUM_RATES-1:0] pick;

    generate
        for (genvar g = 0; g < NUM_RATES; g++) begin : g_rate
            assign pick[g] = ticks[g] && (sel == SEL_W'(g + 1));
        end
    endgenerate

    assign hit = |pick;

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import irq_ctrl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  flags_t set,
    input  logic   clr,
    output flags_t flags
);
    always_ff @(posedge clk) begin
        if (rst)      flags <= '0;
        else if (clr) flags <= set;
        else          flags <= flags | set;
    end

    // R8
    clear_on_read_chk: assert property (@(posedge clk) disable iff (rst)
        (clr && set == '0) |=> flags == '0);

    // R9
    flags_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !clr |=> ((flags & $past(flags)) == $past(flags)));

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int DW     = DATA_W,
    parameter int NRATES = NUM_RATES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [7:0]        addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    input  logic [7:0]        now_sec,
    input  logic [7:0]        now_min,
    input  logic [7:0]        now_hr,
    input  logic [NRATES-1:0] tick_vec,
    input  logic              pwr_fail,
    output logic              irq_low
);
    localparam int SEL_W = $clog2(NRATES + 1);

    ctrl_t  ctrl_q;
    flags_t flags;
    flags_t set;
    logic   alarm_rise;
    logic   tick_hit;
    logic   status_rd;

    always_ff @(posedge clk) begin
        if (rst)                             ctrl_q <= '0;
        else if (wr_en && addr == ADDR_CTRL) ctrl_q <= ctrl_t'(wdata[5:0]);
    end

    irq_alarm_unit #(.DW(DW)) u_alarm (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .now        (to_tod(now_sec, now_min, now_hr)),
        .alarm_rise (alarm_rise)
    );

    irq_tick_sel #(.NUM_RATES(NRATES), .SEL_W(SEL_W)) u_tick (
        .sel   (ctrl_q.rate[SEL_W-1:0]),
        .ticks (tick_vec),
        .hit   (tick_hit)
    );

    always_comb begin
        set.alarm = alarm_rise && ctrl_q.alarm_en;
        set.tick  = tick_hit;
        set.pwr   = pwr_fail && ctrl_q.pwr_en;
    end

    assign status_rd = rd_en && (addr == ADDR_STATUS);

    irq_flag_bank u_flags (
        .clk   (clk),
        .rst   (rst),
        .set   (set),
        .clr   (status_rd),
        .flags (flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            case (addr)
                ADDR_STATUS: rdata <= DW'(status_byte(flags));
                ADDR_CTRL:   rdata <= DW'(ctrl_byte(ctrl_q));
                default:     rdata <= '0;
            endcase
        end
    end

    assign irq_low = |flags;

    // R2
    alarm_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flags.alarm) |-> $past(ctrl_q.alarm_en));

    // R6
    pwr_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flags.pwr) |-> $past(ctrl_q.pwr_en));

    // R10
    wo_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (addr == ADDR_ALM_SEC || addr == ADDR_ALM_MIN ||
                   addr == ADDR_ALM_HR)) |=> rdata == '0);

    // R5
    rate_off_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.rate == '0 && !status_rd && !flags.tick) |=> !flags.tick);

endmodule

// File: tb/irq_ctrl_test.sv
`timescale 1ns/1ps
module irq_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [7:0]  now_sec = 8'h7F;
    logic [7:0]  now_min = 8'h00;
    logic [7:0]  now_hr = 8'h00;
    logic [14:0] tick_vec = '0;
    logic        pwr_fail = 1'b0;
    logic        irq_low;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    irq_ctrl uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .now_sec(now_sec), .now_min(now_min),
        .now_hr(now_hr), .tick_vec(tick_vec), .pwr_fail(pwr_fail),
        .irq_low(irq_low)
    );

    // {alarm sec, min, hr, live sec, min, hr, expect alarm}
    localparam logic [48:0] VEC [8] = '{
        {8'h56, 8'h34, 8'h12, 8'h56, 8'h34, 8'h12, 1'b1},
        {8'h56, 8'h34, 8'h12, 8'h57, 8'h34, 8'h12, 1'b0},
        {8'h56, 8'h34, 8'h12, 8'h56, 8'h35, 8'h12, 1'b0},
        {8'h56, 8'h34, 8'h12, 8'h56, 8'h34, 8'h13, 1'b0},
        {8'h00, 8'h15, 8'h27, 8'h00, 8'h15, 8'h27, 1'b1},
        {8'h00, 8'h15, 8'h27, 8'h00, 8'h15, 8'h07, 1'b0},
        {8'h30, 8'h59, 8'h23, 8'hB0, 8'h59, 8'hE3, 1'b1},
        {8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1}
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act,
                       input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        rd_en = 1'b1; addr = a;
        step();
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        logic [7:0] exp_st;
        @(negedge clk);
        step();
        rst = 1'b0;
        step();

        // R1 reset state
        chk("R1 irq", {7'b0, irq_low}, 8'h00);
        rd(8'h30, d); chk("R1 status", d, 8'h00);
        rd(8'h32, d); chk("R1 ctrl", d, 8'h00);

        // R2 R3 R11 table walk, alarm enabled
        wr(8'h32, 8'h10);
        rd(8'h32, d); chk("R7 ctrl readback", d, 8'h10);
        for (int i = 0; i < 8; i++) begin
            now_sec = 8'h7F; now_min = 8'h00; now_hr = 8'h00;
            step();
            wr(8'h28, VEC[i][48:41]);
            wr(8'h29, VEC[i][40:33]);
            wr(8'h2A, VEC[i][32:25]);
            now_sec = VEC[i][24:17];
            now_min = VEC[i][16:9];
            now_hr  = VEC[i][8:1];
            step();
            exp_st = {7'b0, VEC[i][0]};
            chk("R2 R3 R11 irq", {7'b0, irq_low}, exp_st);
            rd(8'h30, d);
            chk("R2 R3 R11 status", d, exp_st);
            if (VEC[i][0]) begin
                chk("R8 irq released", {7'b0, irq_low}, 8'h00);
                repeat (3) step();
                rd(8'h30, d);
                chk("R4 no re-raise", d, 8'h00);
            end
        end

        // R10 write-only alarm and unmapped reads
        rd(8'h28, d); chk("R10 alarm sec read", d, 8'h00);
        rd(8'h2A, d); chk("R10 alarm hr read", d, 8'h00);
        rd(8'h11, d); chk("R10 unmapped read", d, 8'h00);

        // R2 alarm disabled: match entry ignored
        wr(8'h32, 8'h00);
        now_sec = 8'h7F; step();
        wr(8'h28, 8'h05); wr(8'h29, 8'h00); wr(8'h2A, 8'h00);
        now_sec = 8'h05; now_min = 8'h00; now_hr = 8'h00;
        step();
        chk("R2 disabled irq", {7'b0, irq_low}, 8'h00);
        rd(8'h30, d); chk("R2 disabled status", d, 8'h00);

        // R5 periodic selection
        wr(8'h32, 8'h05);
        tick_vec = 15'h0010; step(); tick_vec = '0;
        chk("R5 k5 irq", {7'b0, irq_low}, 8'h01);
        rd(8'h30, d); chk("R5 k5 status", d, 8'h02);
        tick_vec = 15'h7FEF; step(); tick_vec = '0;
        chk("R5 other ticks irq", {7'b0, irq_low}, 8'h00);
        wr(8'h32, 8'h0F);
        tick_vec = 15'h4000; step(); tick_vec = '0;
        // R9 sticky flag
        repeat (5) step();
        chk("R9 sticky irq", {7'b0, irq_low}, 8'h01);
        rd(8'h30, d); chk("R5 k15 status", d, 8'h02);
        wr(8'h32, 8'h01);
        tick_vec = 15'h0001; step(); tick_vec = '0;
        rd(8'h30, d); chk("R5 k1 status", d, 8'h02);
        wr(8'h32, 8'h00);
        tick_vec = 15'h7FFF; step(); tick_vec = '0;
        chk("R5 k0 irq", {7'b0, irq_low}, 8'h00);
        rd(8'h30, d); chk("R5 k0 status", d, 8'h00);

        // R6 power-fail gating
        pwr_fail = 1'b1; step(); pwr_fail = 1'b0;
        chk("R6 disabled irq", {7'b0, irq_low}, 8'h00);
        wr(8'h32, 8'h20);
        pwr_fail = 1'b1; step(); pwr_fail = 1'b0;
        chk("R6 enabled irq", {7'b0, irq_low}, 8'h01);

        // R8 event coincident with status read survives
        rd_en = 1'b1; addr = 8'h30; pwr_fail = 1'b1;
        step();
        rd_en = 1'b0; pwr_fail = 1'b0;
        chk("R8 read data", rdata, 8'h04);
        chk("R8 coincident irq", {7'b0, irq_low}, 8'h01);
        rd(8'h30, d); chk("R8 coincident status", d, 8'h04);
        chk("R8 irq after read", {7'b0, irq_low}, 8'h00);

        // R7 combined causes
        wr(8'h32, 8'h23);
        tick_vec = 15'h0004; pwr_fail = 1'b1; step();
        tick_vec = '0; pwr_fail = 1'b0;
        rd(8'h30, d); chk("R7 combined status", d, 8'h06);

        // R1 reset mid-run
        tick_vec = 15'h0004; step(); tick_vec = '0;
        rst = 1'b1; step(); rst = 1'b0; step();
        chk("R1 reset irq", {7'b0, irq_low}, 8'h00);
        rd(8'h32, d); chk("R1 reset ctrl", d, 8'h00);

        finish_run();
    end

endmodule